// File: doc/BRIEF.md
# Residue-Sum Overflow Classifier and Exact Sum Rebuilder

This block takes two operands held in a three-modulus residue system whose moduli are 2^N+1, 2^N and 2^N-1. The dynamic range is M = (2^N+1)·2^N·(2^N-1). Each operand arrives as three mixed-radix digits from an upstream digit evaluator: d1 in [0, 2^N], d2 in [0, 2^N-1] and d3 in [0, 2^N-2], with weights 1, 2^N+1 and (2^N+1)·2^N. Each operand also carries a flag that marks it as lying in the upper half of the range, that is, X ≥ M/2.

The block is purely combinational. It reports whether the true sum X+Y reaches M. When both flags are set the answer is always yes. When both are clear the answer is always no. When exactly one flag is set, the result of the sum rebuild decides it.

The block also returns the exact unwrapped binary sum Z = X+Y, which stays correct when the sum passes M. To form Z, it adds the digits pairwise and weights each pair sum with shifts only. It then folds the five shifted terms through a chain of carry-save stages and resolves them with one carry-propagate add.

Top module: `rns_ovf_fix`

## Requirements
- R1: For any legal digit inputs, `z_sum` equals X+Y as an unsigned binary number, where X = a_d1 + a_d2·(2^N+1) + a_d3·(2^N+1)·2^N, and Y is formed the same way from the b_ digits.
- R2: When both `a_hi` and `b_hi` are 1, `ovf` is 1.
- R3: When both `a_hi` and `b_hi` are 0, `ovf` is 0. This includes the all-zero input, which gives `z_sum` = 0.
- R4: When exactly one of `a_hi` and `b_hi` is 1, `ovf` is 1 if and only if X+Y ≥ M.
- R5: At the range boundary, a sum of exactly M-1 gives `ovf` = 0, and a sum of exactly M gives `ovf` = 1.
- R6: For N = 2 (M = 60), the sum 49+21 gives `ovf` = 1 with `z_sum` = 70, and the sum 10+11 gives `ovf` = 0 with `z_sum` = 21.
- R7: The largest legal sum, 2M-2, is returned exactly on the 3N+2-bit `z_sum` output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_d1 | input | N+1 | First operand, unit-weight digit (0..2^N) |
| a_d2 | input | N | First operand, digit of weight 2^N+1 |
| a_d3 | input | N | First operand, digit of weight (2^N+1)·2^N |
| a_hi | input | 1 | First operand lies in [M/2, M) |
| b_d1 | input | N+1 | Second operand, unit-weight digit |
| b_d2 | input | N | Second operand, middle digit |
| b_d3 | input | N | Second operand, top digit |
| b_hi | input | 1 | Second operand lies in [M/2, M) |
| ovf | output | 1 | True sum is at least M |
| z_sum | output | 3N+2 | Exact unwrapped sum X+Y |

## Verification
Overflow classification and the exact sum rebuild are evaluated together for every operand pair. In the mixed-flag case the flag is taken from the rebuilt sum, so one wrong carry shows up in both outputs at once. The bench covers this with every operand pair for N = 2, random pairs for N = 4 and N = 6, and directed pairs that land exactly on M-1, M and 2M-2. Each vector is scored on both outputs against X+Y and (X+Y ≥ M), which the bench computes from the integers and not from the digits.

// File: rtl/rns_ovf_pkg.sv
package rns_ovf_pkg;

  // Dynamic range of the three-modulus set for a given N.
  function automatic logic [63:0] f_dyn_range(input int n);
    logic [63:0] p;
    p = 64'd1 << n;
    return (p + 64'd1) * p * (p - 64'd1);
  endfunction

  // Bit width of the unwrapped sum output.
  function automatic int f_sum_width(input int n);
    return 3 * n + 2;
  endfunction

  // Number of shifted partial terms fed to the carry-save chain.
  localparam int NUM_TERMS = 5;

  // Majority of three bits, used by the 3:2 cell.
  function automatic logic f_maj(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Half-range classes derived from the two upper-half flags.
  typedef enum logic [1:0] {
    CLS_BOTH_LOW  = 2'b00,
    CLS_SPLIT     = 2'b01,
    CLS_BOTH_HIGH = 2'b10
  } half_cls_e;

  function automatic half_cls_e f_classify(input logic ha, input logic hb);
    if (ha && hb)        return CLS_BOTH_HIGH;
    else if (ha || hb)   return CLS_SPLIT;
    else                 return CLS_BOTH_LOW;
  endfunction

endpackage

// File: rtl/rns_digit_pair_add.sv
module rns_digit_pair_add
  import rns_ovf_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N:0]   a_d1,
  input  logic [N-1:0] a_d2,
  input  logic [N-1:0] a_d3,
  input  logic [N:0]   b_d1,
  input  logic [N-1:0] b_d2,
  input  logic [N-1:0] b_d3,
  output logic [N+1:0] psi1,
  output logic [N:0]   psi2,
  output logic [N:0]   psi3
);

  localparam logic [N:0]   D1_MAX  = (N+1)'(1) << N;
  localparam logic [N-1:0] D3_MAX  = N'((64'd1 << N) - 64'd2);

  always_comb begin
    psi1 = {1'b0, a_d1} + {1'b0, b_d1};
    psi2 = {1'b0, a_d2} + {1'b0, b_d2};
    psi3 = {1'b0, a_d3} + {1'b0, b_d3};
  end

  // Input contract and pair-sum ranges.
  always_comb begin
    AST_DIGIT1_RANGE: assert (a_d1 <= D1_MAX && b_d1 <= D1_MAX)
      else $error("unit digit out of range"); // R1
    AST_DIGIT3_RANGE: assert (a_d3 <= D3_MAX && b_d3 <= D3_MAX)
      else $error("top digit out of range"); // R1
    AST_PSI1_BOUND: assert (psi1 <= {D1_MAX, 1'b0})
      else $error("unit pair sum above twice the modulus"); // R1
    AST_PSI3_BOUND: assert (psi3 <= {1'b0, D3_MAX} + {1'b0, D3_MAX})
      else $error("top pair sum out of range"); // R7
  end

endmodule

// File: rtl/rns_csa32.sv
module rns_csa32
  import rns_ovf_pkg::*;
#(
  parameter int W = 14
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);

  logic [W-1:0] maj_bits;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign maj_bits[i] = f_maj(in_a[i], in_b[i], in_c[i]);
  end

  assign sum_o = in_a ^ in_b ^ in_c;
  assign cry_o = {maj_bits[W-2:0], 1'b0};

  // Value preserved through the 3:2 reduction (modulo 2^W).
  always_comb begin
    AST_CSA_PRESERVES: assert (W'(in_a + in_b + in_c) == W'(sum_o + cry_o))
      else $error("carry-save stage changed the value"); // R1
  end

endmodule

// File: rtl/rns_weight_sum.sv
module rns_weight_sum
  import rns_ovf_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N+1:0]             psi1,
  input  logic [N:0]               psi2,
  input  logic [N:0]               psi3,
  output logic [f_sum_width(N)-1:0] z_out
);

  localparam int          ZW     = f_sum_width(N);
  localparam int          STAGES = NUM_TERMS - 2;
  localparam logic [ZW-1:0] Z_CEIL = ZW'(2 * f_dyn_range(N) - 2);

  // Shifted partial terms: psi1, psi2, psi2<<N, psi3<<N, psi3<<2N.
  logic [ZW-1:0] term [NUM_TERMS];

  assign term[0] = ZW'(psi1);
  assign term[1] = ZW'(psi2);
  assign term[2] = ZW'(psi2) << N;
  assign term[3] = ZW'(psi3) << N;
  assign term[4] = ZW'(psi3) << (2 * N);

  logic [ZW-1:0] st_sum [STAGES];
  logic [ZW-1:0] st_cry [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_csa
    if (k == 0) begin : g_first
      rns_csa32 #(.W(ZW)) u_csa (
        .in_a (term[0]),
        .in_b (term[1]),
        .in_c (term[2]),
        .sum_o(st_sum[k]),
        .cry_o(st_cry[k])
      );
    end else begin : g_next
      rns_csa32 #(.W(ZW)) u_csa (
        .in_a (st_sum[k-1]),
        .in_b (st_cry[k-1]),
        .in_c (term[k+2]),
        .sum_o(st_sum[k]),
        .cry_o(st_cry[k])
      );
    end
  end

  // Single carry-propagate resolution.
  assign z_out = st_sum[STAGES-1] + st_cry[STAGES-1];

  always_comb begin
    AST_Z_CEILING: assert (z_out <= Z_CEIL)
      else $error("rebuilt sum exceeds 2M-2"); // R7
    AST_Z_FLOOR_TOP: assert (z_out >= (ZW'(psi3) << (2 * N)))
      else $error("rebuilt sum below its top-weight term"); // R1
  end

endmodule

// File: rtl/rns_ovf_classify.sv
module rns_ovf_classify
  import rns_ovf_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                      a_hi,
  input  logic                      b_hi,
  input  logic [f_sum_width(N)-1:0] z_in,
  output logic                      ovf
);

  localparam int            ZW    = f_sum_width(N);
  localparam logic [ZW-1:0] M_VAL = ZW'(f_dyn_range(N));

  half_cls_e cls;
  logic      both_hi;
  logic      both_lo;
  logic      split;
  logic      z_reaches_m;

  assign cls         = f_classify(a_hi, b_hi);
  assign both_hi     = (cls == CLS_BOTH_HIGH);
  assign both_lo     = (cls == CLS_BOTH_LOW);
  assign split       = (cls == CLS_SPLIT);
  assign z_reaches_m = (z_in >= M_VAL);

  always_comb begin
    unique case (cls)
      CLS_BOTH_HIGH: ovf = 1'b1;
      CLS_BOTH_LOW:  ovf = 1'b0;
      default:       ovf = z_reaches_m;
    endcase
  end

  always_comb begin
    AST_CLASS_ONEHOT: assert ($onehot({both_hi, both_lo, split}))
      else $error("half-range class not unique"); // R4
    if (both_hi) begin
      AST_BOTH_UPPER: assert (ovf)
        else $error("two upper-half operands without overflow"); // R2
    end
    if (both_lo) begin
      AST_NO_OVERFLOW: assert (!ovf)
        else $error("two lower-half operands flagged overflow"); // R3
    end
    if (!split) begin
      AST_FLAG_MATCHES_SUM: assert (ovf == z_reaches_m)
        else $error("flag disagrees with rebuilt sum"); // R1
    end
  end

endmodule

// File: rtl/rns_ovf_fix.sv
module rns_ovf_fix
  import rns_ovf_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N:0]       a_d1,
  input  logic [N-1:0]     a_d2,
  input  logic [N-1:0]     a_d3,
  input  logic             a_hi,
  input  logic [N:0]       b_d1,
  input  logic [N-1:0]     b_d2,
  input  logic [N-1:0]     b_d3,
  input  logic             b_hi,
  output logic             ovf,
  output logic [3*N+1:0]   z_sum
);

  localparam int ZW = f_sum_width(N);

  logic [N+1:0]  psi1;
  logic [N:0]    psi2;
  logic [N:0]    psi3;
  logic [ZW-1:0] z_rebuilt;

  rns_digit_pair_add #(.N(N)) u_pair (
    .a_d1(a_d1), .a_d2(a_d2), .a_d3(a_d3),
    .b_d1(b_d1), .b_d2(b_d2), .b_d3(b_d3),
    .psi1(psi1), .psi2(psi2), .psi3(psi3)
  );

  rns_weight_sum #(.N(N)) u_weight (
    .psi1 (psi1),
    .psi2 (psi2),
    .psi3 (psi3),
    .z_out(z_rebuilt)
  );

  rns_ovf_classify #(.N(N)) u_cls (
    .a_hi(a_hi),
    .b_hi(b_hi),
    .z_in(z_rebuilt),
    .ovf (ovf)
  );

  assign z_sum = z_rebuilt;

endmodule

// File: tb/rns_ovf_fix_tb.sv
module rns_ovf_fix_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk; // 125 MHz

  // N = 2 instance
  logic [2:0]  a2_d1 = '0, b2_d1 = '0;
  logic [1:0]  a2_d2 = '0, a2_d3 = '0, b2_d2 = '0, b2_d3 = '0;
  logic        a2_hi = 1'b0, b2_hi = 1'b0, ovf2;
  logic [7:0]  z2;
  // N = 4 instance
  logic [4:0]  a4_d1 = '0, b4_d1 = '0;
  logic [3:0]  a4_d2 = '0, a4_d3 = '0, b4_d2 = '0, b4_d3 = '0;
  logic        a4_hi = 1'b0, b4_hi = 1'b0, ovf4;
  logic [13:0] z4;
  // N = 6 instance
  logic [6:0]  a6_d1 = '0, b6_d1 = '0;
  logic [5:0]  a6_d2 = '0, a6_d3 = '0, b6_d2 = '0, b6_d3 = '0;
  logic        a6_hi = 1'b0, b6_hi = 1'b0, ovf6;
  logic [19:0] z6;

  rns_ovf_fix #(.N(2)) u_dut (
    .a_d1(a2_d1), .a_d2(a2_d2), .a_d3(a2_d3), .a_hi(a2_hi),
    .b_d1(b2_d1), .b_d2(b2_d2), .b_d3(b2_d3), .b_hi(b2_hi),
    .ovf(ovf2), .z_sum(z2));
  rns_ovf_fix #(.N(4)) u_dut4 (
    .a_d1(a4_d1), .a_d2(a4_d2), .a_d3(a4_d3), .a_hi(a4_hi),
    .b_d1(b4_d1), .b_d2(b4_d2), .b_d3(b4_d3), .b_hi(b4_hi),
    .ovf(ovf4), .z_sum(z4));
  rns_ovf_fix #(.N(6)) u_dut6 (
    .a_d1(a6_d1), .a_d2(a6_d2), .a_d3(a6_d3), .a_hi(a6_hi),
    .b_d1(b6_d1), .b_d2(b6_d2), .b_d3(b6_d3), .b_hi(b6_hi),
    .ovf(ovf6), .z_sum(z6));

  typedef struct {
    int     n;
    longint z_exp;
    bit     ovf_exp;
    string  tag;
  } item_t;

  item_t  sb_q[$];
  int     checks = 0;
  int     errors = 0;
  bit     done = 0;

  function automatic longint range_of(int n);
    longint p = longint'(1) << n;
    return (p + 1) * p * (p - 1);
  endfunction

  // Mixed-radix digits computed by division, independent of the design.
  function automatic void to_digits(int n, longint x, output longint e1,
                                    output longint e2, output longint e3,
                                    output bit hi);
    longint m1 = (longint'(1) << n) + 1;
    longint m2 = longint'(1) << n;
    e1 = x % m1;
    e2 = (x / m1) % m2;
    e3 = x / (m1 * m2);
    hi = (x >= range_of(n) / 2);
  endfunction

  task automatic apply(int n, longint x, longint y, string tag);
    longint ax1, ax2, ax3, by1, by2, by3;
    bit     ahi, bhi;
    item_t  it;
    to_digits(n, x, ax1, ax2, ax3, ahi);
    to_digits(n, y, by1, by2, by3, bhi);
    @(posedge clk);
    case (n)
      2: begin
        a2_d1 = 3'(ax1); a2_d2 = 2'(ax2); a2_d3 = 2'(ax3); a2_hi = ahi;
        b2_d1 = 3'(by1); b2_d2 = 2'(by2); b2_d3 = 2'(by3); b2_hi = bhi;
      end
      4: begin
        a4_d1 = 5'(ax1); a4_d2 = 4'(ax2); a4_d3 = 4'(ax3); a4_hi = ahi;
        b4_d1 = 5'(by1); b4_d2 = 4'(by2); b4_d3 = 4'(by3); b4_hi = bhi;
      end
      default: begin
        a6_d1 = 7'(ax1); a6_d2 = 6'(ax2); a6_d3 = 6'(ax3); a6_hi = ahi;
        b6_d1 = 7'(by1); b6_d2 = 6'(by2); b6_d3 = 6'(by3); b6_hi = bhi;
      end
    endcase
    it.n       = n;
    it.z_exp   = x + y;
    it.ovf_exp = (x + y >= range_of(n));
    if (tag != "")        it.tag = tag;
    else if (ahi && bhi)  it.tag = "R2";
    else if (!ahi && !bhi) it.tag = "R3";
    else                  it.tag = "R4";
    sb_q.push_back(it);
  endtask

  // Monitor: scores each item half a cycle after it is driven.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && sb_q.size() > 0) begin
        item_t  it;
        longint z_act;
        bit     o_act;
        it = sb_q.pop_front();
        case (it.n)
          2:       begin z_act = longint'(z2); o_act = ovf2; end
          4:       begin z_act = longint'(z4); o_act = ovf4; end
          default: begin z_act = longint'(z6); o_act = ovf6; end
        endcase
        checks++;
        if (z_act != it.z_exp) begin
          errors++;
          $display("FAIL R1 (%s) n=%0d z_sum actual %0d expected %0d",
                   it.tag, it.n, z_act, it.z_exp);
        end
        checks++;
        if (o_act != it.ovf_exp) begin
          errors++;
          $display("FAIL %s n=%0d ovf actual %0d expected %0d",
                   it.tag, it.n, o_act, it.ovf_exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    longint m4 = range_of(4);
    longint m6 = range_of(6);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R3: idle all-zero inputs give zero sum and no flag
    apply(2, 0, 0, "R3");
    apply(4, 0, 0, "R3");
    // R6: worked vectors for N = 2
    apply(2, 49, 21, "R6");
    apply(2, 10, 11, "R6");
    // R5: range boundary, split and both-upper cases
    apply(4, m4 / 2 - 1, m4 / 2, "R5");
    apply(4, m4 / 2, m4 / 2, "R5");
    apply(6, m6 / 2 - 1, m6 / 2, "R5");
    apply(6, m6 / 2, m6 / 2, "R5");
    apply(4, m4 - 1, 0, "R5");
    apply(4, m4 - 1, 1, "R5");
    // R7: largest legal sum
    apply(2, 59, 59, "R7");
    apply(4, m4 - 1, m4 - 1, "R7");
    apply(6, m6 - 1, m6 - 1, "R7");
    // R1..R4: every pair for N = 2
    for (int x = 0; x < 60; x++)
      for (int y = 0; y < 60; y++)
        apply(2, longint'(x), longint'(y), "");
    // R1..R4: random pairs for N = 4 and N = 6
    for (int i = 0; i < 2000; i++)
      apply(4, longint'($urandom % 32'(m4)), longint'($urandom % 32'(m4)), "");
    for (int i = 0; i < 2000; i++)
      apply(6, longint'($urandom % 32'(m6)), longint'($urandom % 32'(m6)), "");
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule